// File: doc/BRIEF.md
# Wormhole Router Input Port with Credit Return

This block is the receive side of one link into a wormhole-switched on-chip router. Flits arrive from the upstream neighbour with a valid strobe and go into a four-entry FIFO. The upstream sender keeps a credit counter that starts at the buffer depth. This port pulses a credit back each time a flit leaves toward the crossbar. The port does not apply ready/valid backpressure, so a flit that arrives with no free slot means the sender broke the protocol. Such a flit is flagged and thrown away.

Every 36-bit flit carries its own framing flags. The port reads them in two places. On the input side it watches for a new packet that starts before the previous one has closed. On the output side it drives the crossbar request. A head flit at the front of the FIFO raises a route request for the output number in its payload. Once that head flit is granted, the port remembers the output. The body and tail flits then follow on that output and do not arbitrate again. The output choice comes with each packet, so adaptive routing can pick a different output for every packet.

Top module: `wh_input_port`

## Requirements
- R1: After reset the buffer is empty, outValid, routeReq, creditOut and both error outputs are low, and no output is locked, so reqPort reads 0.
- R2: A flit is 36 bits. Bit 35 is the head flag and bit 34 is the tail flag. Bits 33:32 are reserved and change nothing. Bits 31:0 are payload. The destination output of a head flit is payload bits [PORT_W-1:0] (3 bits by default). A flit with neither flag set is a body flit.
- R3: The buffer holds up to 4 flits and presents them on outFlit in arrival order. outValid is high whenever at least one flit is held.
- R4: A flit presented with inValid while 4 flits are held is not stored. overflowErr is high in that same cycle, and the buffer contents and order stay unchanged.
- R5: creditOut is high for exactly the cycles in which a flit leaves, that is, when outValid and grant are both high. grant while the buffer is empty gives no credit.
- R6: routeReq is high only while the front flit is a head flit. In that case reqPort equals that flit's destination field.
- R7: After a head flit without the tail flag leaves, the following body and tail flits are offered with routeReq low, and reqPort holds the locked output. The lock is released when the tail flit leaves. While nothing is buffered, reqPort shows the last locked output.
- R8: A flit with both head and tail set is a one-flit packet. It raises routeReq, and after it leaves it leaves no lock behind and no packet open on the input side.
- R9: A head flit accepted while an earlier input packet has not yet seen its tail raises framingErr in that cycle. The flit is still stored.
- R10: A flit written into an empty buffer appears on outFlit, with outValid high, in the cycle after its arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream flit strobe |
| inFlit | input | 36 | Upstream flit word |
| creditOut | output | 1 | One-cycle credit returned upstream per departing flit |
| outValid | output | 1 | Front flit available toward the crossbar |
| outFlit | output | 36 | Front flit word |
| routeReq | output | 1 | Front flit is a head flit requesting an output |
| reqPort | output | PORT_W (3) | Requested or locked output number |
| grant | input | 1 | Crossbar accepts the front flit this cycle |
| overflowErr | output | 1 | Flit arrived with the buffer full and was dropped |
| framingErr | output | 1 | Head flit arrived inside an open packet |

## Verification
Several properties are checked by the assertions on every cycle. The occupancy never passes the depth. A dropped flit leaves the occupancy changed only by a pop. Every credit matches exactly one departure. The output lock stays fixed across body flits and opens once a tail has left. A route request always comes with a valid flit. Some behaviour can only be shown by the bench's scenarios: the flits come out in arrival order with their contents intact, a dropped flit never appears later, the destination field is read from the right bits, and the locked output number, rather than the head's, shows on reqPort during a worm.

// File: rtl/wh_pkg.sv
package wh_pkg;
  // Framing flag positions inside the flit word; the routing decode relies on them.
  localparam int HEAD_BIT = 35;
  localparam int TAIL_BIT = 34;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;
    logic pop;
  } strobe_t;
endpackage

// File: rtl/wh_fifo_dp.sv
module wh_fifo_dp #(
  parameter int FLIT_W = 36,
  parameter int DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  wh_pkg::strobe_t    strb,
  input  logic [FLIT_W-1:0]  inFlit,
  output logic [FLIT_W-1:0]  frontFlit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= inFlit;
  end

  assign frontFlit = mem[rdPtr];
endmodule

// File: rtl/wh_port_ctrl.sv
module wh_port_ctrl #(
  parameter int DEPTH  = 4,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inHead,
  input  logic              inTail,
  input  logic              grant,
  input  logic              frontHead,
  input  logic              frontTail,
  input  logic [PORT_W-1:0] frontPort,
  output wh_pkg::strobe_t   strb,
  output logic              outValid,
  output logic              routeReq,
  output logic [PORT_W-1:0] reqPort,
  output logic              creditOut,
  output logic              overflowErr,
  output logic              framingErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0]  cnt;
  logic              locked;
  logic [PORT_W-1:0] lockPort;
  logic              inOpen;
  logic              frontIsHead;

  assign outValid    = (cnt != '0);
  assign overflowErr = inValid && (cnt == FULL);
  assign strb.push   = inValid && (cnt != FULL);
  assign strb.pop    = outValid && grant;
  assign creditOut   = strb.pop;
  assign frontIsHead = outValid && frontHead;
  assign routeReq    = frontIsHead;
  assign reqPort     = frontIsHead ? frontPort : lockPort;
  assign framingErr  = strb.push && inHead && inOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      locked   <= 1'b0;
      lockPort <= '0;
      inOpen   <= 1'b0;
    end else begin
      cnt <= cnt + CNT_W'(strb.push) - CNT_W'(strb.pop);
      if (strb.pop) begin
        if (frontHead && !frontTail) begin
          locked   <= 1'b1;
          lockPort <= frontPort;
        end else if (frontTail) begin
          locked   <= 1'b0;
        end
      end
      if (strb.push) begin
        if (inHead && !inTail) inOpen <= 1'b1;
        else if (inTail)       inOpen <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL); // R3
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> (cnt + CNT_W'($past(strb.pop))) == $past(cnt)); // R4
  AST_CREDIT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    creditOut |=> (cnt + 1'b1) == ($past(cnt) + CNT_W'($past(strb.push)))); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (locked && strb.pop && !frontHead && !frontTail) |=> (locked && $stable(lockPort))); // R7
  AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && frontTail) |=> !locked); // R8
endmodule

// File: rtl/wh_input_port.sv
module wh_input_port #(
  parameter int FLIT_W = 36,
  parameter int DEPTH  = 4,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FLIT_W-1:0] inFlit,
  output logic              creditOut,
  output logic              outValid,
  output logic [FLIT_W-1:0] outFlit,
  output logic              routeReq,
  output logic [PORT_W-1:0] reqPort,
  input  logic              grant,
  output logic              overflowErr,
  output logic              framingErr
);
  import wh_pkg::*;

  strobe_t strb;

  wh_fifo_dp #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inFlit(inFlit), .frontFlit(outFlit)
  );

  wh_port_ctrl #(.DEPTH(DEPTH), .PORT_W(PORT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inHead(inFlit[HEAD_BIT]), .inTail(inFlit[TAIL_BIT]),
    .grant(grant),
    .frontHead(outFlit[HEAD_BIT]), .frontTail(outFlit[TAIL_BIT]),
    .frontPort(outFlit[PORT_W-1:0]),
    .strb(strb), .outValid(outValid), .routeReq(routeReq), .reqPort(reqPort),
    .creditOut(creditOut), .overflowErr(overflowErr), .framingErr(framingErr)
  );

  AST_REQ_NEEDS_FLIT: assert property (@(posedge clk) disable iff (!rstN)
    routeReq |-> outValid); // R6
endmodule

// File: tb/sim_wh_input_port.sv
module sim_wh_input_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [35:0] inFlit = '0;
  logic grant = 1'b0;
  logic creditOut, outValid, routeReq, overflowErr, framingErr;
  logic [35:0] outFlit;
  logic [2:0] reqPort;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wh_input_port u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFlit(inFlit),
    .creditOut(creditOut), .outValid(outValid), .outFlit(outFlit),
    .routeReq(routeReq), .reqPort(reqPort), .grant(grant),
    .overflowErr(overflowErr), .framingErr(framingErr)
  );

  typedef struct packed {
    logic        vld;
    logic [35:0] flit;
    logic        gnt;
    logic        eVld;
    logic        eReq;
    logic [2:0]  ePort;
    logic        eCred;
    logic        eOvf;
    logic        eFrm;
    logic [35:0] eFlit;
  } vec_t;

  localparam vec_t VEC [17] = '{
    '{1'b0, 36'h0,           1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 36'h0},
    '{1'b1, 36'h8_1111_1003, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 36'h0},
    '{1'b1, 36'h0_2222_2222, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 36'h8_1111_1003},
    '{1'b1, 36'h4_3333_3333, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 36'h8_1111_1003},
    '{1'b1, 36'hC_4444_4001, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 36'h8_1111_1003},
    '{1'b1, 36'h0_5555_5555, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 36'h8_1111_1003},
    '{1'b0, 36'h0,           1'b1, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 36'h8_1111_1003},
    '{1'b0, 36'h0,           1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 36'h0_2222_2222},
    '{1'b0, 36'h0,           1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 36'h0_2222_2222},
    '{1'b1, 36'h8_6666_6005, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 36'h4_3333_3333},
    '{1'b1, 36'h8_7777_7002, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 36'hC_4444_4001},
    '{1'b0, 36'h0,           1'b1, 1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 36'hC_4444_4001},
    '{1'b0, 36'h0,           1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 36'h8_6666_6005},
    '{1'b0, 36'h0,           1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 36'h8_6666_6005},
    '{1'b0, 36'h0,           1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 36'h8_7777_7002},
    '{1'b0, 36'h0,           1'b1, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 36'h8_7777_7002},
    '{1'b0, 36'h0,           1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 36'h0}
  };

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [35:0] f, input logic g);
    @(posedge clk);
    #1;
    inValid = v;
    inFlit  = f;
    grant   = g;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: idle state right after reset
    check("R1 outValid", 36'(outValid), 36'd0);
    check("R1 creditOut", 36'(creditOut), 36'd0);
    check("R1 reqPort", 36'(reqPort), 36'd0);

    // R2 R3 R4 R5 R6 R7 R8 R9 R10: table walk
    for (int i = 0; i < 17; i++) begin
      drive(VEC[i].vld, VEC[i].flit, VEC[i].gnt);
      check($sformatf("R3/R10 outValid v%0d", i), 36'(outValid), 36'(VEC[i].eVld));
      check($sformatf("R6 routeReq v%0d", i), 36'(routeReq), 36'(VEC[i].eReq));
      check($sformatf("R7 reqPort v%0d", i), 36'(reqPort), 36'(VEC[i].ePort));
      check($sformatf("R5 creditOut v%0d", i), 36'(creditOut), 36'(VEC[i].eCred));
      check($sformatf("R4 overflowErr v%0d", i), 36'(overflowErr), 36'(VEC[i].eOvf));
      check($sformatf("R9 framingErr v%0d", i), 36'(framingErr), 36'(VEC[i].eFrm));
      if (VEC[i].eVld)
        check($sformatf("R3 outFlit v%0d", i), outFlit, VEC[i].eFlit);
    end

    // R2: reserved bits set on a body flit do not make it a head
    drive(1'b1, 36'h3_0000_0006, 1'b0);
    drive(1'b0, 36'h0, 1'b0);
    check("R2 reserved body no req", 36'(routeReq), 36'd0);
    check("R2 reserved flit stored", outFlit, 36'h3_0000_0006);
    drive(1'b0, 36'h0, 1'b1);
    check("R5 credit on pop", 36'(creditOut), 36'd1);

    // R1: reset in the middle of a worm clears the lock and the buffer
    drive(1'b1, 36'h8_0000_0004, 1'b0);
    drive(1'b1, 36'h0_0000_0000, 1'b1);
    check("R7 lock pending head", 36'(reqPort), 36'd4);
    @(posedge clk);
    #1 rstN = 1'b0;
    inValid = 1'b0;
    grant = 1'b1;
    @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 empty after reset", 36'(outValid), 36'd0);
    check("R1 no credit after reset", 36'(creditOut), 36'd0);
    check("R1 lock cleared", 36'(reqPort), 36'd0);

    // R9: after reset no packet is open, so a head raises no framing error
    drive(1'b1, 36'h8_0000_0001, 1'b0);
    check("R9 no error after reset", 36'(framingErr), 36'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule